// File: doc/BRIEF.md
# Host Interrupt and Control Register Slice

This block is the register slice a storage controller exposes to its host. It holds a control word (hard and soft reset requests, a timestamp-disable flag and a global interrupt enable), a read-only device status word assembled from live inputs, a sticky interrupt status word that software clears by writing ones, and an interrupt mask. Internal logic reports events as single-cycle pulses. Each pulse sets its own bit in the status word and keeps it set until software clears it.

The block raises one interrupt request. The request is active when any status bit is pending, that bit is enabled in the mask, and the global enable is on. Alongside the request the block reports a 4-bit message code for a message-signalled interrupt. The code belongs to the lowest-numbered event that is both pending and enabled. Access is through a simple bus: a write is taken on the clock edge while the select and write inputs are high, and read data is combinational from the address while the select input is high and the write input is low.

Top module: `hostint_regs`

## Requirements
- R1: After reset the control word reads 0, the interrupt status reads 0, the mask reads 0x7E7 (every event bit except 3 and 4), and irqReq is 0.
- R2: The control word is at offset 0x500, the device status word at 0x510, the interrupt status at 0x520 and the mask at 0x528. Any other offset reads 0, and a write to it changes no register.
- R3: The device status word reads devState in bits 7:0, devSig in bits 15:8, devDmaMode in bit 16 and 0 in all other bits. Writes to it are ignored.
- R4: Control bits 1 (soft reset, driven on softRstReq), 6 (timestamp disable, driven on tsDisable) and 7 (interrupt enable) are read/write. All other control bits except bit 0 read 0.
- R5: A control write with bit 0 set clears every interrupt status and mask bit on that edge, including events that arrive in the same cycle. Bit 0 then reads 1 for exactly one cycle and 0 after that.
- R6: An event pulse on evtPulse[i], for i in {0,1,2,5..10}, sets status bit i on the next edge. The bit stays set until it is cleared.
- R7: A write to the interrupt status clears each bit that is written as 1 and leaves the other bits unchanged. If an event pulse hits the same bit in the same cycle, the bit stays set.
- R8: Bits 3 and 4 of the interrupt status and of the mask always read 0, and events and writes do not change them. Bits 31:11 of both registers also read 0.
- R9: irqReq is 1 exactly when control bit 7 is set and (status AND mask) is non-zero. A mask bit of 1 enables its source.
- R10: irqCode is the code of the lowest-numbered bit that is both pending and enabled: bit 0→4, 1→5, 2→6, 5→9, 6→10, 7→11, 8→12, 9→0, 10→1. irqCode is 0 when no bit is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data (combinational) |
| devState | input | 8 | Drive state code (0x00 offline … 0xFF missing) |
| devSig | input | 8 | Signature byte |
| devDmaMode | input | 1 | PIO/DMA mode flag |
| evtPulse | input | 11 | Single-cycle event pulses, one per status bit |
| irqReq | output | 1 | Interrupt request |
| irqCode | output | 4 | Message code of the lowest pending enabled event |
| softRstReq | output | 1 | Soft reset request (control bit 1) |
| tsDisable | output | 1 | Timestamp disable (control bit 6) |

## Verification
The bench builds the block with its default parameters: a 12-bit offset space, a 32-bit data word and the fixed 11-bit event map. The event map is small, so the bench can sweep every single event, every pair of events (for the priority order and partial clears) and every one-hot mask, and it computes each expected code from the bit index. It also walks every drive state code through the status word and covers three same-cycle collisions: a hard reset against an event, a clearing write against an event, and writes to the read-only word.

// File: rtl/hostint_pkg.sv
package hostint_pkg;
  localparam int EVT_N = 11;
  localparam int CODE_W = 4;
  localparam logic [EVT_N-1:0] EVT_VALID = 11'h7E7;
  localparam logic [EVT_N-1:0] MASK_DEFAULT = EVT_VALID;
  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_RW = 8'hC2;
  localparam int HARD_BIT = 0;
  localparam int SOFT_BIT = 1;
  localparam int TS_BIT = 6;
  localparam int IEN_BIT = 7;

  typedef struct packed {
    logic wrCtrl;
    logic wrIsr;
    logic wrMask;
    logic rdCtrl;
    logic rdStat;
    logic rdIsr;
    logic rdMask;
  } strobe_t;

  function automatic logic [CODE_W-1:0] msgCode(input int idx);
    logic [CODE_W-1:0] c;
    c = '0;
    if ((idx >= 0 && idx <= 2) || (idx >= 5 && idx <= 8)) c = CODE_W'(idx + 4);
    else if (idx == 9) c = CODE_W'(0);
    else if (idx == 10) c = CODE_W'(1);
    return c;
  endfunction
endpackage

// File: rtl/hostint_ctrl.sv
module hostint_ctrl
  import hostint_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h500,
  parameter logic [ADDR_W-1:0] STAT_OFF = 12'h510,
  parameter logic [ADDR_W-1:0] ISR_OFF = 12'h520,
  parameter logic [ADDR_W-1:0] MASK_OFF = 12'h528
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic isWr, isRd;
  assign isWr = busSel & busWr;
  assign isRd = busSel & ~busWr;

  always_comb begin
    strb = '0;
    strb.wrCtrl = isWr && (busAddr == CTRL_OFF);
    strb.wrIsr  = isWr && (busAddr == ISR_OFF);
    strb.wrMask = isWr && (busAddr == MASK_OFF);
    strb.rdCtrl = isRd && (busAddr == CTRL_OFF);
    strb.rdStat = isRd && (busAddr == STAT_OFF);
    strb.rdIsr  = isRd && (busAddr == ISR_OFF);
    strb.rdMask = isRd && (busAddr == MASK_OFF);
  end

  // R2: at most one register is addressed per access
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrIsr, strb.wrMask, strb.rdCtrl,
              strb.rdStat, strb.rdIsr, strb.rdMask}));
endmodule

// File: rtl/hostint_dpath.sv
module hostint_dpath
  import hostint_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [7:0]        devState,
  input  logic [7:0]        devSig,
  input  logic              devDmaMode,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic [CODE_W-1:0] irqCode,
  output logic              softRstReq,
  output logic              tsDisable
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [EVT_N-1:0]  isrReg, maskReg, pending;
  logic              hardWr;
  logic [EVT_N-1:0]  wrEvt;

  assign hardWr = strb.wrCtrl & busWdata[HARD_BIT];
  assign wrEvt  = busWdata[EVT_N-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      isrReg  <= '0;
      maskReg <= MASK_DEFAULT;
    end else begin
      ctrlReg[HARD_BIT] <= hardWr;
      if (strb.wrCtrl)
        ctrlReg[CTRL_W-1:1] <= busWdata[CTRL_W-1:1] & CTRL_RW[CTRL_W-1:1];
      if (hardWr) begin
        isrReg  <= '0;
        maskReg <= '0;
      end else begin
        isrReg <= ((isrReg & ~(strb.wrIsr ? wrEvt : '0)) | evtPulse) & EVT_VALID;
        if (strb.wrMask) maskReg <= wrEvt & EVT_VALID;
      end
    end
  end

  assign pending    = isrReg & maskReg;
  assign irqReq     = ctrlReg[IEN_BIT] & (|pending);
  assign softRstReq = ctrlReg[SOFT_BIT];
  assign tsDisable  = ctrlReg[TS_BIT];

  always_comb begin
    irqCode = '0;
    for (int i = EVT_N - 1; i >= 0; i--)
      if (pending[i]) irqCode = msgCode(i);
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdCtrl) busRdata = DATA_W'(ctrlReg);
    if (strb.rdStat) busRdata = DATA_W'({devDmaMode, devSig, devState});
    if (strb.rdIsr)  busRdata = DATA_W'(isrReg);
    if (strb.rdMask) busRdata = DATA_W'(maskReg);
  end

  // R5: hard reset wipes status and mask and shows bit 0 for a cycle
  p_hard_wipe_r5: assert property (@(posedge clk) disable iff (!rstN)
    hardWr |=> (isrReg == '0 && maskReg == '0 && ctrlReg[HARD_BIT]));
  p_hard_selfclr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[HARD_BIT] && !hardWr) |=> !ctrlReg[HARD_BIT]);
  // R6: every valid pulse is captured
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!hardWr && |evtPulse) |=>
      ((isrReg & $past(evtPulse & EVT_VALID)) == $past(evtPulse & EVT_VALID)));
  // R7: written ones clear unless an event collides
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIsr && !hardWr) |=> ((isrReg & $past(wrEvt & ~evtPulse)) == '0));
  // R8: mask write keeps only defined bits
  p_mask_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && !hardWr) |=> (maskReg == $past(wrEvt & EVT_VALID)));
endmodule

// File: rtl/hostint_regs.sv
module hostint_regs
  import hostint_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h500,
  parameter logic [ADDR_W-1:0] STAT_OFF = 12'h510,
  parameter logic [ADDR_W-1:0] ISR_OFF = 12'h520,
  parameter logic [ADDR_W-1:0] MASK_OFF = 12'h528
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [7:0]        devState,
  input  logic [7:0]        devSig,
  input  logic              devDmaMode,
  input  logic [10:0]       evtPulse,
  output logic              irqReq,
  output logic [3:0]        irqCode,
  output logic              softRstReq,
  output logic              tsDisable
);
  strobe_t strb;

  hostint_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF),
    .ISR_OFF(ISR_OFF), .MASK_OFF(MASK_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strb(strb)
  );

  hostint_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .devState(devState), .devSig(devSig), .devDmaMode(devDmaMode),
    .evtPulse(evtPulse), .busRdata(busRdata), .irqReq(irqReq),
    .irqCode(irqCode), .softRstReq(softRstReq), .tsDisable(tsDisable)
  );
endmodule

// File: tb/sim_hostint_regs.sv
`timescale 1ns/1ps
module sim_hostint_regs;
  localparam logic [11:0] A_CTRL = 12'h500, A_STAT = 12'h510,
                          A_ISR = 12'h520, A_MASK = 12'h528;
  localparam logic [31:0] VALID = 32'h7E7;

  logic clk = 0, rstN = 0, busSel = 0, busWr = 0, devDmaMode = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [7:0] devState = '0, devSig = '0;
  logic [10:0] evtPulse = '0;
  logic irqReq, softRstReq, tsDisable;
  logic [3:0] irqCode;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  hostint_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .devState(devState),
    .devSig(devSig), .devDmaMode(devDmaMode), .evtPulse(evtPulse),
    .irqReq(irqReq), .irqCode(irqCode), .softRstReq(softRstReq),
    .tsDisable(tsDisable)
  );

  function automatic logic [3:0] expCode(input int i);
    if (i <= 2 || (i >= 5 && i <= 8)) return 4'(i + 4);
    if (i == 9) return 4'd0;
    if (i == 10) return 4'd1;
    return 4'd0;
  endfunction

  function automatic logic [3:0] lowCode(input logic [31:0] p);
    for (int i = 0; i < 11; i++) if (p[i]) return expCode(i);
    return 4'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wrEvt(input logic [11:0] a, input logic [31:0] d, input logic [10:0] e);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d; evtPulse = e;
    @(posedge clk); #1;
    busSel = 0; busWr = 0; evtPulse = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wrEvt(a, d, '0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk); evtPulse = e;
    @(posedge clk); #1 evtPulse = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ctl, msk;
    logic [7:0] states [14] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                                8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'hFE, 8'hFF};
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_ISR, v);  chk("R1 isr", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, VALID);
    chk("R1 irqReq", irqReq, 0);

    // R3 status word composition over every state code
    for (int s = 0; s < 14; s++) begin
      devState = states[s]; devSig = 8'(s * 17 + 3); devDmaMode = s[0];
      rd(A_STAT, v);
      chk("R3 status", v, {15'b0, devDmaMode, devSig, devState});
    end
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R3 write ignored", v, {15'b0, devDmaMode, devSig, devState});

    // R2 unmapped offsets
    rd(12'h504, v); chk("R2 unmapped read", v, 0);
    rd(12'h600, v); chk("R2 unmapped read", v, 0);
    wr(12'h524, 32'hFFFF_FFFE);
    rd(A_MASK, v); chk("R2 stray write mask", v, VALID);
    rd(A_CTRL, v); chk("R2 stray write ctrl", v, 0);

    // R4 control bits
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, v); chk("R4 ctrl rw", v, 32'hC2);
    chk("R4 softRstReq", softRstReq, 1);
    chk("R4 tsDisable", tsDisable, 1);
    wr(A_CTRL, 0);
    chk("R4 softRstReq off", softRstReq, 0);

    // R6 R8 R9 R10 R7 single-event sweep
    wr(A_CTRL, 32'h80);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, v); chk("R8 mask reserved", v, VALID);
    for (int i = 0; i < 11; i++) begin
      pulse(11'(1 << i));
      rd(A_ISR, v); chk("R6 capture", v, (32'(1) << i) & VALID);
      pulse('0);
      rd(A_ISR, v); chk("R6 sticky", v, (32'(1) << i) & VALID);
      chk("R9 irqReq", irqReq, |((32'(1) << i) & VALID));
      chk("R10 code", irqCode, lowCode((32'(1) << i) & VALID));
      wr(A_ISR, 32'h7FF);
      rd(A_ISR, v); chk("R7 clear", v, 0);
    end

    // R10 R7 pairwise priority and partial clear
    for (int i = 0; i < 11; i++)
      for (int j = i + 1; j < 11; j++) begin
        pulse(11'((1 << i) | (1 << j)));
        chk("R10 pair code", irqCode, lowCode(32'((1 << i) | (1 << j)) & VALID));
        wr(A_ISR, 32'(1) << i);
        rd(A_ISR, v); chk("R7 partial clear", v, (32'(1) << j) & VALID);
        chk("R10 after clear", irqCode, lowCode((32'(1) << j) & VALID));
        wr(A_ISR, 32'hFFFF_FFFF);
      end

    // R9 R10 R8 one-hot mask sweep with everything pending
    pulse(11'h7FF);
    for (int k = 0; k < 11; k++) begin
      wr(A_MASK, 32'(1) << k);
      rd(A_MASK, v); chk("R8 mask onehot", v, (32'(1) << k) & VALID);
      chk("R9 masked irq", irqReq, VALID[k]);
      chk("R10 masked code", irqCode, lowCode((32'(1) << k) & VALID));
    end
    wr(A_MASK, 32'h7FF);
    wr(A_CTRL, 0);
    chk("R9 global disable", irqReq, 0);
    chk("R10 code w/o enable", irqCode, 4'd4);
    wr(A_CTRL, 32'h80);

    // R7 event collides with clearing write
    wr(A_ISR, 32'h7FF);
    pulse(11'h002);
    wrEvt(A_ISR, 32'h002, 11'h002);
    rd(A_ISR, v); chk("R7 collision keeps bit", v, 32'h2);

    // R5 hard reset with a colliding event
    wrEvt(A_CTRL, 32'h81, 11'h020);
    rd(A_CTRL, ctl); chk("R5 bit0 visible", ctl, 32'h81);
    rd(A_CTRL, ctl); chk("R5 bit0 self clear", ctl, 32'h80);
    rd(A_ISR, v);  chk("R5 isr cleared", v, 0);
    rd(A_MASK, msk); chk("R5 mask cleared", msk, 0);
    chk("R5 irqReq", irqReq, 0);

    summary();
  end
endmodule